// File: doc/BRIEF.md
# Masked Status and Delegation Control Register File

This block holds the machine status word, the interrupt pending, enable and delegation words, two counter-enable words and a host message word for a processor core. Software reaches it through one access port: a 12-bit register address, write data, a valid strobe and a write flag. Each access returns read data and an illegal flag one cycle later. The read data shows the state as it was before any write made by the same access. The timer and host interrupt pending bits also have external set and clear inputs, so that a timer or host agent can raise or drop them without going through software.

Every write goes through a legality mask. The supervisor status, pending and enable registers have no storage of their own. They are filtered windows onto the machine registers: the status window exposes a fixed set of fields, and the pending and enable windows expose only the bits named in the delegation word. Counter values come in from outside the block. A read of a user or supervisor counter succeeds only when the matching counter-enable bit allows it.

Top module: `csr_ctl_file`

## Requirements
- R1: The delegation word (address 0x303) accepts writes only to bit 1 (supervisor software), bit 5 (supervisor timer), bit 9 (host) and bit 11 (coprocessor). Every other bit keeps its value, so a write of all ones reads back as 0xA22.
- R2: A software write to the pending word (address 0x344) can change only bits 1, 3 (machine software) and 5. A read access never changes those bits.
- R3: The enable word (address 0x304) accepts writes only to bits 1, 3, 5, 7 (machine timer), 9 and 11, so a write of all ones reads back as 0xAAA.
- R4: A read of the supervisor pending view (0x144) or the supervisor enable view (0x104) returns the machine word ANDed with the delegation word. A write to either view changes only the delegated bits that are writable in the machine word.
- R5: The supervisor status view (0x100) exposes these status fields: bit 1 supervisor enable, bit 5 supervisor previous-enable, bit 8 supervisor previous-privilege, bits 14:13 float state, bits 16:15 extension state and bit 18 user-memory-protect. A write to the view modifies only those fields. The machine status word (0x300) also has machine enable at bit 3, machine previous-enable at bit 7, previous-privilege at bits 12:11 and memory-privilege at bit 17.
- R6: A read of the supervisor status view sets bit 31 when the float state field or the extension state field equals 3. The machine status word stores 0 in bit 31.
- R7: The machine previous-privilege field (bits 12:11) takes a written value only when that value is 0, 1 or 3. A written value of 2 leaves the field unchanged, while the other writable fields are still updated.
- R8: The user counter-enable word (0x306) and the supervisor counter-enable word (0x106) each store only their low 3 bits. Counter index 0 is cycle, 1 is time and 2 is retired instructions. Machine counters at 0xB00+i always read. A user counter at 0xC00+i returns the counter only if bit i of the user enable word is set, and a supervisor counter at 0xD00+i only if bit i of the supervisor enable word is set. Otherwise the read returns zero and flags illegal.
- R9: A write to the host word (0x7C1) sets the host pending bit (bit 9) when the value is nonzero and clears it when the value is zero. The external inputs then act on the timer bit (bit 7) and the host bit: set wins over clear, and both win over a write in the same cycle.
- R10: An access to an unknown address returns zero and raises the illegal flag for exactly one cycle. Read data and the flag are registered: they appear one cycle after the access, show the state from before that access, and return to zero in a cycle with no access.
- R11: After reset every stored word is zero, and the read data and the illegal flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 12 | Register address |
| acc_wdata | input | XLEN | Write data |
| tmr_set | input | 1 | Raise the machine timer pending bit |
| tmr_clr | input | 1 | Drop the machine timer pending bit |
| hst_set | input | 1 | Raise the host pending bit |
| hst_clr | input | 1 | Drop the host pending bit |
| cnt_vals | input | NCNT*XLEN | Counter values, index i at bits i*XLEN upward |
| rd_data | output | XLEN | Read data, one cycle after the access |
| rd_illegal | output | 1 | Illegal access flag, one cycle after the access |
| stat_q | output | XLEN | Machine status word |
| pend_q | output | 12 | Interrupt pending word |
| enab_q | output | 12 | Interrupt enable word |
| deleg_q | output | 12 | Interrupt delegation word |

## Verification
The assertions assume that at most one access is presented per cycle and that acc_write is meaningful only while acc_valid is high. The timing assertion also assumes that the timer inputs change only between clock edges. The bench drives every input on the falling edge and keeps the strobe low between accesses. It pulses the external set and clear lines only in isolated cycles, or together on purpose to check which one wins. Counter inputs stay at fixed values, so a gated counter read has a single expected result.

// File: rtl/csr_ctl_pkg.sv
package csr_ctl_pkg;
    localparam int IRQ_W = 12;

    localparam int B_SSI  = 1;
    localparam int B_MSI  = 3;
    localparam int B_STI  = 5;
    localparam int B_MTI  = 7;
    localparam int B_HOST = 9;
    localparam int B_COP  = 11;

    localparam logic [IRQ_W-1:0] DELEG_MASK = 12'hA22;
    localparam logic [IRQ_W-1:0] PEND_SW_MASK = 12'h02A;
    localparam logic [IRQ_W-1:0] ENAB_MASK = 12'hAAA;

    localparam logic [31:0] ST_M_BASE = 32'h0006_61AA;
    localparam logic [31:0] ST_XS     = 32'h0001_8000;
    localparam logic [31:0] ST_MPP    = 32'h0000_1800;
    localparam logic [31:0] ST_S_VIEW = 32'h0005_E122;
    localparam int ST_FS_LO  = 13;
    localparam int ST_XS_LO  = 15;
    localparam int ST_MPP_LO = 11;

    localparam logic [11:0] A_MSTATUS  = 12'h300;
    localparam logic [11:0] A_MDELEG   = 12'h303;
    localparam logic [11:0] A_MENAB    = 12'h304;
    localparam logic [11:0] A_UCNTEN   = 12'h306;
    localparam logic [11:0] A_MPEND    = 12'h344;
    localparam logic [11:0] A_SSTATUS  = 12'h100;
    localparam logic [11:0] A_SENAB    = 12'h104;
    localparam logic [11:0] A_SCNTEN   = 12'h106;
    localparam logic [11:0] A_SPEND    = 12'h144;
    localparam logic [11:0] A_HOSTWORD = 12'h7C1;
    localparam logic [3:0]  BANK_M = 4'hB;
    localparam logic [3:0]  BANK_U = 4'hC;
    localparam logic [3:0]  BANK_S = 4'hD;
endpackage

// File: rtl/csr_status_view.sv
module csr_status_view
    import csr_ctl_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter bit EXT_EN = 1'b1
) (
    input  logic [XLEN-1:0] status_q,
    input  logic [XLEN-1:0] wdata,
    input  logic            m_we,
    input  logic            s_we,
    output logic [XLEN-1:0] status_d,
    output logic [XLEN-1:0] s_view
);
    localparam logic [XLEN-1:0] XS_W  = EXT_EN ? XLEN'(ST_XS) : '0;
    localparam logic [XLEN-1:0] S_MSK = XLEN'(ST_S_VIEW);

    logic [XLEN-1:0] m_mask;
    logic [1:0] fs_f;
    logic [1:0] xs_f;

    always_comb begin
        m_mask = XLEN'(ST_M_BASE) | XS_W;
        if (wdata[ST_MPP_LO+1:ST_MPP_LO] != 2'b10) begin
            m_mask = m_mask | XLEN'(ST_MPP);
        end
        status_d = status_q;
        if (m_we) begin
            status_d = (status_q & ~m_mask) | (wdata & m_mask);
        end else if (s_we) begin
            status_d = (status_q & ~S_MSK) | (wdata & S_MSK);
        end
        fs_f = status_q[ST_FS_LO+1:ST_FS_LO];
        xs_f = status_q[ST_XS_LO+1:ST_XS_LO];
        s_view = status_q & S_MSK;
        if (fs_f == 2'b11 || xs_f == 2'b11) begin
            s_view[XLEN-1] = 1'b1;
        end
    end
endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
    import csr_ctl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [IRQ_W-1:0] pend_q,
    input  logic [IRQ_W-1:0] enab_q,
    input  logic [IRQ_W-1:0] deleg_q,
    input  logic [XLEN-1:0]  wdata,
    input  logic             we_mpend,
    input  logic             we_spend,
    input  logic             we_menab,
    input  logic             we_senab,
    input  logic             we_deleg,
    input  logic             we_host,
    input  logic             tmr_set,
    input  logic             tmr_clr,
    input  logic             hst_set,
    input  logic             hst_clr,
    output logic [IRQ_W-1:0] pend_d,
    output logic [IRQ_W-1:0] enab_d,
    output logic [IRQ_W-1:0] deleg_d
);
    logic [IRQ_W-1:0] w_low;
    logic [IRQ_W-1:0] msk;

    always_comb begin
        w_low = wdata[IRQ_W-1:0];
        pend_d = pend_q;
        if (we_mpend) begin
            msk = PEND_SW_MASK;
        end else if (we_spend) begin
            msk = PEND_SW_MASK & deleg_q;
        end else begin
            msk = '0;
        end
        pend_d = (pend_d & ~msk) | (w_low & msk);
        if (we_host) begin
            pend_d[B_HOST] = |wdata;
        end
        if (tmr_clr) pend_d[B_MTI] = 1'b0;
        if (tmr_set) pend_d[B_MTI] = 1'b1;
        if (hst_clr) pend_d[B_HOST] = 1'b0;
        if (hst_set) pend_d[B_HOST] = 1'b1;

        enab_d = enab_q;
        if (we_menab) begin
            enab_d = (enab_q & ~ENAB_MASK) | (w_low & ENAB_MASK);
        end else if (we_senab) begin
            enab_d = (enab_q & ~(ENAB_MASK & deleg_q)) | (w_low & ENAB_MASK & deleg_q);
        end

        deleg_d = deleg_q;
        if (we_deleg) begin
            deleg_d = (deleg_q & ~DELEG_MASK) | (w_low & DELEG_MASK);
        end
    end
endmodule

// File: rtl/csr_counter_gate.sv
module csr_counter_gate
    import csr_ctl_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NCNT = 3
) (
    input  logic [11:0]                addr,
    input  logic [NCNT-1:0][XLEN-1:0]  cnt_vals,
    input  logic [NCNT-1:0]            ucen,
    input  logic [NCNT-1:0]            scen,
    output logic                       hit,
    output logic                       deny,
    output logic [XLEN-1:0]            value
);
    logic [NCNT-1:0]           sel;
    logic [NCNT-1:0][XLEN-1:0] part;
    logic bank_m, bank_u, bank_s;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        assign sel[i]  = (addr[7:0] == 8'(i));
        assign part[i] = sel[i] ? cnt_vals[i] : '0;
    end

    always_comb begin
        bank_m = (addr[11:8] == BANK_M);
        bank_u = (addr[11:8] == BANK_U);
        bank_s = (addr[11:8] == BANK_S);
        hit = (bank_m || bank_u || bank_s) && (|sel);
        deny = hit && ((bank_u && ((sel & ucen) == '0)) ||
                       (bank_s && ((sel & scen) == '0)));
        value = '0;
        for (int i = 0; i < NCNT; i++) begin
            value = value | part[i];
        end
        if (deny) value = '0;
    end
endmodule

// File: rtl/csr_ctl_file.sv
module csr_ctl_file
    import csr_ctl_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NCNT   = 3,
    parameter bit EXT_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [11:0]           acc_addr,
    input  logic [XLEN-1:0]       acc_wdata,
    input  logic                  tmr_set,
    input  logic                  tmr_clr,
    input  logic                  hst_set,
    input  logic                  hst_clr,
    input  logic [NCNT*XLEN-1:0]  cnt_vals,
    output logic [XLEN-1:0]       rd_data,
    output logic                  rd_illegal,
    output logic [XLEN-1:0]       stat_q,
    output logic [IRQ_W-1:0]      pend_q,
    output logic [IRQ_W-1:0]      enab_q,
    output logic [IRQ_W-1:0]      deleg_q
);
    typedef struct packed {
        logic [XLEN-1:0]  status;
        logic [IRQ_W-1:0] pend;
        logic [IRQ_W-1:0] enab;
        logic [IRQ_W-1:0] deleg;
        logic [NCNT-1:0]  ucen;
        logic [NCNT-1:0]  scen;
        logic [XLEN-1:0]  host;
        logic [XLEN-1:0]  rdata;
        logic             illegal;
    } regs_t;

    regs_t st_d, st_q;

    logic we;
    logic h_mst, h_sst, h_mpend, h_spend, h_menab, h_senab, h_deleg;
    logic h_ucen, h_scen, h_host, reg_hit;
    logic [XLEN-1:0]  status_nx, s_view;
    logic [IRQ_W-1:0] pend_nx, enab_nx, deleg_nx;
    logic cnt_hit, cnt_deny;
    logic [XLEN-1:0] cnt_val;
    logic [XLEN-1:0] rval;
    logic [NCNT-1:0][XLEN-1:0] cnt_arr;

    assign cnt_arr = cnt_vals;
    assign we      = acc_valid & acc_write;
    assign h_mst   = (acc_addr == A_MSTATUS);
    assign h_sst   = (acc_addr == A_SSTATUS);
    assign h_mpend = (acc_addr == A_MPEND);
    assign h_spend = (acc_addr == A_SPEND);
    assign h_menab = (acc_addr == A_MENAB);
    assign h_senab = (acc_addr == A_SENAB);
    assign h_deleg = (acc_addr == A_MDELEG);
    assign h_ucen  = (acc_addr == A_UCNTEN);
    assign h_scen  = (acc_addr == A_SCNTEN);
    assign h_host  = (acc_addr == A_HOSTWORD);
    assign reg_hit = h_mst | h_sst | h_mpend | h_spend | h_menab | h_senab |
                     h_deleg | h_ucen | h_scen | h_host;

    csr_status_view #(.XLEN(XLEN), .EXT_EN(EXT_EN)) u_stat (
        .status_q (st_q.status),
        .wdata    (acc_wdata),
        .m_we     (we & h_mst),
        .s_we     (we & h_sst),
        .status_d (status_nx),
        .s_view   (s_view)
    );

    csr_irq_unit #(.XLEN(XLEN)) u_irq (
        .pend_q   (st_q.pend),
        .enab_q   (st_q.enab),
        .deleg_q  (st_q.deleg),
        .wdata    (acc_wdata),
        .we_mpend (we & h_mpend),
        .we_spend (we & h_spend),
        .we_menab (we & h_menab),
        .we_senab (we & h_senab),
        .we_deleg (we & h_deleg),
        .we_host  (we & h_host),
        .tmr_set  (tmr_set),
        .tmr_clr  (tmr_clr),
        .hst_set  (hst_set),
        .hst_clr  (hst_clr),
        .pend_d   (pend_nx),
        .enab_d   (enab_nx),
        .deleg_d  (deleg_nx)
    );

    csr_counter_gate #(.XLEN(XLEN), .NCNT(NCNT)) u_cnt (
        .addr     (acc_addr),
        .cnt_vals (cnt_arr),
        .ucen     (st_q.ucen),
        .scen     (st_q.scen),
        .hit      (cnt_hit),
        .deny     (cnt_deny),
        .value    (cnt_val)
    );

    always_comb begin
        rval = '0;
        if (h_mst)   rval = st_q.status;
        if (h_sst)   rval = s_view;
        if (h_mpend) rval = XLEN'(st_q.pend);
        if (h_spend) rval = XLEN'(st_q.pend & st_q.deleg);
        if (h_menab) rval = XLEN'(st_q.enab);
        if (h_senab) rval = XLEN'(st_q.enab & st_q.deleg);
        if (h_deleg) rval = XLEN'(st_q.deleg);
        if (h_ucen)  rval = XLEN'(st_q.ucen);
        if (h_scen)  rval = XLEN'(st_q.scen);
        if (h_host)  rval = st_q.host;
        if (cnt_hit) rval = cnt_val;

        st_d        = st_q;
        st_d.status = status_nx;
        st_d.pend   = pend_nx;
        st_d.enab   = enab_nx;
        st_d.deleg  = deleg_nx;
        if (we && h_ucen) st_d.ucen = acc_wdata[NCNT-1:0];
        if (we && h_scen) st_d.scen = acc_wdata[NCNT-1:0];
        if (we && h_host) st_d.host = acc_wdata;
        st_d.illegal = acc_valid & (~(reg_hit | cnt_hit) | cnt_deny);
        st_d.rdata   = (acc_valid && !st_d.illegal) ? rval : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rdata;
    assign rd_illegal = st_q.illegal;
    assign stat_q     = st_q.status;
    assign pend_q     = st_q.pend;
    assign enab_q     = st_q.enab;
    assign deleg_q    = st_q.deleg;
endmodule

// File: rtl/csr_ctl_file_chk.sv
module csr_ctl_file_chk
    import csr_ctl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             tmr_set,
    input logic             tmr_clr,
    input logic             rd_illegal,
    input logic [XLEN-1:0]  rd_data,
    input logic [XLEN-1:0]  stat_q,
    input logic [IRQ_W-1:0] pend_q,
    input logic [IRQ_W-1:0] deleg_q
);
    AST_DELEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (deleg_q & ~DELEG_MASK) == '0); // R1
    AST_READ_KEEPS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> (pend_q & PEND_SW_MASK) == $past(pend_q & PEND_SW_MASK)); // R2
    AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[ST_MPP_LO+1:ST_MPP_LO] != 2'b10); // R7
    AST_TMR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_set |=> pend_q[B_MTI]); // R9
    AST_TMR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr && !tmr_set |=> !pend_q[B_MTI]); // R9
    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> $past(acc_valid)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (rd_data == '0 && !rd_illegal)); // R10
endmodule

bind csr_ctl_file csr_ctl_file_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .tmr_set    (tmr_set),
    .tmr_clr    (tmr_clr),
    .rd_illegal (rd_illegal),
    .rd_data    (rd_data),
    .stat_q     (stat_q),
    .pend_q     (pend_q),
    .deleg_q    (deleg_q)
);

// File: tb/csr_ctl_file_test.sv
`timescale 1ns/1ps
module csr_ctl_file_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        tmr_set = 1'b0, tmr_clr = 1'b0, hst_set = 1'b0, hst_clr = 1'b0;
    logic [95:0] cnt_vals = {32'h33, 32'h22, 32'h11};
    logic [31:0] rd_data, stat_q;
    logic        rd_illegal;
    logic [11:0] pend_q, enab_q, deleg_q;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    csr_ctl_file uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .tmr_set(tmr_set),
        .tmr_clr(tmr_clr), .hst_set(hst_set), .hst_clr(hst_clr),
        .cnt_vals(cnt_vals), .rd_data(rd_data), .rd_illegal(rd_illegal),
        .stat_q(stat_q), .pend_q(pend_q), .enab_q(enab_q), .deleg_q(deleg_q)
    );

    // {write, addr, wdata, read addr, expected, requirement number}
    localparam int NV = 21;
    localparam logic [96:0] VEC [NV] = '{
        {1'b1, 12'h303, 32'hFFFFFFFF, 12'h303, 32'h00000A22, 8'd1},  // R1
        {1'b1, 12'h344, 32'hFFFFFFFF, 12'h344, 32'h0000002A, 8'd2},  // R2
        {1'b1, 12'h304, 32'hFFFFFFFF, 12'h304, 32'h00000AAA, 8'd3},  // R3
        {1'b0, 12'h144, 32'h0,        12'h144, 32'h00000022, 8'd4},  // R4
        {1'b0, 12'h104, 32'h0,        12'h104, 32'h00000A22, 8'd4},  // R4
        {1'b1, 12'h303, 32'h00000002, 12'h303, 32'h00000002, 8'd1},  // R1
        {1'b1, 12'h144, 32'h0,        12'h344, 32'h00000028, 8'd4},  // R4
        {1'b1, 12'h104, 32'h0,        12'h304, 32'h00000AA8, 8'd4},  // R4
        {1'b1, 12'h300, 32'hFFFFFFFF, 12'h300, 32'h0007F9AA, 8'd5},  // R5
        {1'b0, 12'h100, 32'h0,        12'h100, 32'h8005E122, 8'd6},  // R6
        {1'b1, 12'h300, 32'h00001000, 12'h300, 32'h00001800, 8'd7},  // R7
        {1'b1, 12'h100, 32'hFFFFFFFF, 12'h300, 32'h0005F922, 8'd5},  // R5
        {1'b1, 12'h100, 32'h0,        12'h100, 32'h00000000, 8'd6},  // R6
        {1'b1, 12'h300, 32'h00018000, 12'h100, 32'h80018000, 8'd6},  // R6
        {1'b1, 12'h300, 32'h00000800, 12'h300, 32'h00000800, 8'd7},  // R7
        {1'b1, 12'h306, 32'h000000FF, 12'h306, 32'h00000007, 8'd8},  // R8
        {1'b1, 12'h106, 32'h00000005, 12'h106, 32'h00000005, 8'd8},  // R8
        {1'b0, 12'hC01, 32'h0,        12'hC01, 32'h00000022, 8'd8},  // R8
        {1'b0, 12'hD02, 32'h0,        12'hD02, 32'h00000033, 8'd8},  // R8
        {1'b1, 12'h7C1, 32'h00000005, 12'h344, 32'h00000228, 8'd9},  // R9
        {1'b1, 12'h7C1, 32'h0,        12'h344, 32'h00000028, 8'd9}   // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic pulse(input logic ts, input logic tc, input logic hs, input logic hc);
        @(negedge clk);
        tmr_set = ts; tmr_clr = tc; hst_set = hs; hst_clr = hc;
        @(negedge clk);
        tmr_set = 1'b0; tmr_clr = 1'b0; hst_set = 1'b0; hst_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 status", stat_q, 32'h0);
        chk("R11 words", {8'h0, pend_q, enab_q} , 32'h0);
        chk("R11 deleg", {20'h0, deleg_q}, 32'h0);
        chk("R11 read/illegal", {rd_data[30:0], rd_illegal}, 32'h0);
        acc(1'b0, 12'h300, 32'h0);
        chk("R11 status read", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [96:0] v;
            string tag;
            v = VEC[i];
            acc(v[96], v[95:84], v[83:52]);
            acc(1'b0, v[51:40], 32'h0);
            tag = $sformatf("R%0d vector %0d", v[7:0], i);
            chk(tag, rd_data, v[39:8]);
            chk(tag, {31'h0, rd_illegal}, 32'h0);
        end

        // R8 denied supervisor counter, then R10 flag lasts one cycle
        acc(1'b0, 12'hD01, 32'h0);
        chk("R8 denied data", rd_data, 32'h0);
        chk("R8 denied flag", {31'h0, rd_illegal}, 32'h1);
        @(negedge clk);
        chk("R10 flag drops", {31'h0, rd_illegal}, 32'h0);
        acc(1'b0, 12'hC00, 32'h0);
        chk("R8 user cycle", rd_data, 32'h11);
        acc(1'b0, 12'hB02, 32'h0);
        chk("R8 machine instret", rd_data, 32'h33);
        // R10 unknown addresses
        acc(1'b0, 12'h555, 32'h0);
        chk("R10 unknown flag", {31'h0, rd_illegal}, 32'h1);
        chk("R10 unknown data", rd_data, 32'h0);
        acc(1'b0, 12'hC03, 32'h0);
        chk("R10 counter index 3", {31'h0, rd_illegal}, 32'h1);
        // R10 write access returns pre-write value
        acc(1'b1, 12'h303, 32'h00000020);
        chk("R10 pre-write read", rd_data, 32'h00000002);
        acc(1'b0, 12'h303, 32'h0);
        chk("R1 deleg sti", rd_data, 32'h00000020);
        // R9 timer set, set+clear, clear
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        acc(1'b0, 12'h344, 32'h0);
        chk("R9 timer set", rd_data, 32'h000000A8);
        pulse(1'b1, 1'b1, 1'b0, 1'b0);
        acc(1'b0, 12'h344, 32'h0);
        chk("R9 set beats clear", rd_data, 32'h000000A8);
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        acc(1'b0, 12'h344, 32'h0);
        chk("R9 timer clear", rd_data, 32'h00000028);
        // R9 external host set beats zero write in the same cycle
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h7C1; acc_wdata = 32'h0;
        hst_set = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; hst_set = 1'b0;
        acc(1'b0, 12'h344, 32'h0);
        chk("R9 host over write", rd_data, 32'h00000228);
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        acc(1'b0, 12'h344, 32'h0);
        chk("R9 host clear", rd_data, 32'h00000028);
        // R4 supervisor pending write with only timer delegated
        acc(1'b1, 12'h144, 32'h0);
        acc(1'b0, 12'h344, 32'h0);
        chk("R4 sip clears sti only", rd_data, 32'h00000008);
        acc(1'b0, 12'h144, 32'h0);
        chk("R4 sip view", rd_data, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule